// File: doc/BRIEF.md
# Graphics Accelerator Host Bus Front End

This block connects a simple synchronous host bus (22-bit address, 32-bit data, separate read and write strobes, a ready output and two byte-mode inputs) to a 2-D drawing accelerator. The top address bit picks a region. Accesses with that bit set pass straight through to display memory. Accesses with that bit clear reach a small register file, or launch drawing commands toward the drawing engine over a valid/ready handshake.

A host access stays in progress for as long as a strobe is held. It completes in the first cycle in which `hst_ready` is high. Pixel-data writes hold the bus until the engine takes the data. Fill and block-copy commands start on a host read. If that read arrives while an earlier command is still running, it is dropped. The engine signals the end of a command with a done pulse. Software can then poll the status register or wait on the interrupt output.

In the register region, the word index is taken from `hst_addr[5:2]`:

| Index | Register | Access |
|---|---|---|
| 0 | status | bit0 busy, bit1 rejected, bit2 interrupt pending |
| 1 | interrupt enable | bit0 |
| 2 | configuration | bit0 swap |
| 4 | fill launch | read, command code 1 |
| 5 | block-copy launch | read, command code 2 |
| 6 | mono pixel write | write, command code 3 |
| 7 | colour pixel write | write, command code 4 |

Other indices read as 0. Register writes always use the unswapped host data.

Top module: `gfx_host_if`

## Requirements
- R1: Display-memory region (`hst_addr[21]`=1):
  - An access raises `fb_req`.
  - `fb_addr` equals `hst_addr[20:0]`.
  - `fb_we` follows the write strobe.
  - `hst_ready` is 1 at once.
- R2: A register-region access (`hst_addr[21]`=0) never raises `fb_req`.
- R3: When configuration bit0 is 1, the byte order of the 32-bit word is fully reversed in three places:
  - frame-buffer write data (`fb_wdata`);
  - frame-buffer read data returned on `hst_rdata`;
  - pixel data on `eng_data`.

  When bit0 is 0, the data passes through unchanged.
- R4: On a display-memory write, `fb_be` is looked up from code = {`hst_bmode`, `hst_addr[1:0]`}:

  | Code | `fb_be` | Code | `fb_be` |
  |---|---|---|---|
  | 0 | 0001 | 8 | 1110 |
  | 1 | 0010 | 9 | 1101 |
  | 2 | 0100 | 10 | 1011 |
  | 3 | 1000 | 11 | 0110 |
  | 4 | 0011 | 12 | 0101 |
  | 5 | 1100 | 13 | 1010 |
  | 6 | 1111 | 14 | 1001 |
  | 7 | 0111 | 15 | 1111 |

  On reads, `fb_be` is 0000.
- R5: A pixel write (index 6 or 7) drives `eng_valid` with `eng_cmd` 3 or 4 and holds `hst_ready` low until `eng_ready` is 1.
- R6: A launch read (index 4 or 5) while not busy does the following:
  - drives `eng_valid` with `eng_cmd` 1 or 2;
  - waits for `eng_ready`;
  - on completion, sets busy and clears rejected.
- R7: A launch read while busy completes at once, issues no `eng_valid`, and sets the rejected bit.
- R8: An `eng_done` pulse clears busy. If interrupt enable is 1, it also sets interrupt pending. `irq` equals interrupt pending.
- R9: Writing status with data bit2 = 1 clears interrupt pending. An `eng_done` with interrupt enable set in the same cycle wins, and pending stays 1.
- R10: While busy, a configuration write holds `hst_ready` low until busy clears. Status and interrupt-enable writes complete at once.
- R11: After reset, status, interrupt enable and configuration are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 22 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rd | input | 1 | Read strobe |
| hst_wr | input | 1 | Write strobe (wins over read) |
| hst_bmode | input | 2 | Byte-mode pins, upper half of lane code |
| hst_rdata | output | 32 | Host read data |
| hst_ready | output | 1 | Access completes this cycle when high |
| fb_req | output | 1 | Display-memory access |
| fb_we | output | 1 | Display-memory write |
| fb_addr | output | 21 | Display-memory address |
| fb_wdata | output | 32 | Display-memory write data |
| fb_be | output | 4 | Byte-lane enables |
| fb_rdata | input | 32 | Display-memory read data |
| eng_valid | output | 1 | Command/data offered to engine |
| eng_cmd | output | 3 | Command code |
| eng_data | output | 32 | Pixel data |
| eng_ready | input | 1 | Engine accepts offer |
| eng_done | input | 1 | Engine finished a command |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the engine's done pulse and a host write that clears interrupt pending. The bench raises both on one clock edge and expects pending to survive, then repeats the clear alone and expects it to drop. The second pair is a done pulse and a stalled configuration write. The bench starts the write while busy and releases done later, then checks that the write lands only after busy has cleared and that the new swap setting takes effect.

// File: rtl/gfx_host_if.sv
module gfx_host_if #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [1:0]    hst_bmode,
  output logic [31:0]   hst_rdata,
  output logic          hst_ready,
  output logic          fb_req,
  output logic          fb_we,
  output logic [AW-2:0] fb_addr,
  output logic [31:0]   fb_wdata,
  output logic [3:0]    fb_be,
  input  logic [31:0]   fb_rdata,
  output logic          eng_valid,
  output logic [2:0]    eng_cmd,
  output logic [31:0]   eng_data,
  input  logic          eng_ready,
  input  logic          eng_done,
  output logic          irq
);
  localparam logic [3:0] IX_STAT = 4'd0, IX_IEN = 4'd1, IX_CFG = 4'd2,
                         IX_FILL = 4'd4, IX_COPY = 4'd5, IX_PIX1 = 4'd6, IX_PIX8 = 4'd7;

  logic busy, rej, ipend, ien, swp;
  logic [31:0] wd_sw, rd_sw, host_w, mem_r;
  logic [3:0]  lanes;

  wire       upper  = hst_addr[AW-1];
  wire [3:0] idx    = hst_addr[5:2];
  wire       rd     = hst_rd & ~hst_wr;
  wire       lo_rd  = rd & ~upper;
  wire       lo_wr  = hst_wr & ~upper;
  wire       launch = lo_rd & (idx == IX_FILL || idx == IX_COPY);
  wire       pixw   = lo_wr & (idx == IX_PIX1 || idx == IX_PIX8);
  wire       cfgw   = lo_wr & (idx == IX_CFG);
  wire       acc    = (hst_rd | hst_wr) & hst_ready;

  for (genvar i = 0; i < 4; i++) begin : g_swap
    assign wd_sw[8*i +: 8] = hst_wdata[8*(3-i) +: 8];
    assign rd_sw[8*i +: 8] = fb_rdata[8*(3-i) +: 8];
  end
  assign host_w = swp ? wd_sw : hst_wdata;
  assign mem_r  = swp ? rd_sw : fb_rdata;

  always_comb begin
    case ({hst_bmode, hst_addr[1:0]})
      4'd0:  lanes = 4'b0001;
      4'd1:  lanes = 4'b0010;
      4'd2:  lanes = 4'b0100;
      4'd3:  lanes = 4'b1000;
      4'd4:  lanes = 4'b0011;
      4'd5:  lanes = 4'b1100;
      4'd6:  lanes = 4'b1111;
      4'd7:  lanes = 4'b0111;
      4'd8:  lanes = 4'b1110;
      4'd9:  lanes = 4'b1101;
      4'd10: lanes = 4'b1011;
      4'd11: lanes = 4'b0110;
      4'd12: lanes = 4'b0101;
      4'd13: lanes = 4'b1010;
      4'd14: lanes = 4'b1001;
      default: lanes = 4'b1111;
    endcase
  end

  assign fb_req   = upper & (hst_rd | hst_wr);
  assign fb_we    = upper & hst_wr;
  assign fb_addr  = hst_addr[AW-2:0];
  assign fb_wdata = host_w;
  assign fb_be    = fb_we ? lanes : 4'b0000;

  assign eng_valid = (launch & ~busy) | pixw;
  assign eng_data  = pixw ? host_w : 32'd0;
  always_comb begin
    eng_cmd = 3'd0;
    if (eng_valid)
      case (idx)
        IX_FILL: eng_cmd = 3'd1;
        IX_COPY: eng_cmd = 3'd2;
        IX_PIX1: eng_cmd = 3'd3;
        default: eng_cmd = 3'd4;
      endcase
  end

  assign hst_ready = upper           ? 1'b1 :
                     (launch & ~busy) ? eng_ready :
                     pixw            ? eng_ready :
                     cfgw            ? ~busy : 1'b1;

  always_comb begin
    if (upper) hst_rdata = mem_r;
    else
      case (idx)
        IX_STAT: hst_rdata = {29'd0, ipend, rej, busy};
        IX_IEN:  hst_rdata = {31'd0, ien};
        IX_CFG:  hst_rdata = {31'd0, swp};
        default: hst_rdata = 32'd0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rej <= 1'b0; ipend <= 1'b0; ien <= 1'b0; swp <= 1'b0;
    end else begin
      if (eng_done) busy <= 1'b0;
      if (acc && launch) begin
        if (busy) rej <= 1'b1;
        else begin busy <= 1'b1; rej <= 1'b0; end
      end
      if (acc && lo_wr && idx == IX_IEN) ien <= hst_wdata[0];
      if (acc && cfgw) swp <= hst_wdata[0];
      if (acc && lo_wr && idx == IX_STAT && hst_wdata[2]) ipend <= 1'b0;
      if (eng_done && ien) ipend <= 1'b1;
    end
  end

  assign irq = ipend;
endmodule

// File: rtl/gfx_host_if_chk.sv
module gfx_host_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [21:0] hst_addr,
  input logic        hst_rd,
  input logic        hst_wr,
  input logic        hst_ready,
  input logic        fb_req,
  input logic        fb_we,
  input logic [3:0]  fb_be,
  input logic        eng_valid,
  input logic        eng_ready,
  input logic        eng_done,
  input logic        irq,
  input logic        busy,
  input logic        ien
);
  wire lo = ~hst_addr[21];
  wire [3:0] ix = hst_addr[5:2];

  AST_LOWER_NO_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && (hst_rd || hst_wr)) |-> !fb_req); // R2
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req && fb_we) |-> ($countones(fb_be) >= 1)); // R4
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && hst_wr && (ix == 4'd6 || ix == 4'd7) && !eng_ready) |-> !hst_ready); // R5
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_wr && eng_valid && eng_ready) |=> busy); // R6
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && hst_rd && !hst_wr && (ix == 4'd4 || ix == 4'd5) && busy) |-> (!eng_valid && hst_ready)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && busy) |=> !busy); // R8
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && ien) |=> irq); // R9
  AST_CFG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && hst_wr && ix == 4'd2 && busy) |-> !hst_ready); // R10
endmodule

bind gfx_host_if gfx_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
  .hst_ready(hst_ready), .fb_req(fb_req), .fb_we(fb_we), .fb_be(fb_be),
  .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_done(eng_done), .irq(irq),
  .busy(busy), .ien(ien)
);

// File: tb/gfx_host_if_tb.sv
module gfx_host_if_tb;
  logic clk = 0, rst_n = 0;
  logic [21:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, fb_rdata = 0;
  logic hst_rd = 0, hst_wr = 0, eng_ready = 1, eng_done = 0;
  logic [1:0] hst_bmode = 0;
  logic [31:0] hst_rdata, fb_wdata, eng_data;
  logic hst_ready, fb_req, fb_we, eng_valid, irq;
  logic [20:0] fb_addr;
  logic [3:0] fb_be;
  logic [2:0] eng_cmd;

  gfx_host_if u_dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  logic c_req, c_we, c_ev;
  logic [20:0] c_addr;
  logic [3:0] c_be;
  logic [2:0] c_cmd;
  logic [31:0] c_wd, c_ed, c_rd;
  int waits;

  localparam logic [21:0] A_STAT = 22'h00, A_IEN = 22'h04, A_CFG = 22'h08,
                          A_FILL = 22'h10, A_COPY = 22'h14, A_PIX1 = 22'h18, A_PIX8 = 22'h1C;

  function automatic logic [3:0] exp_be(input logic [3:0] c);
    case (c)
      0: return 4'b0001;  1: return 4'b0010;  2: return 4'b0100;  3: return 4'b1000;
      4: return 4'b0011;  5: return 4'b1100;  6: return 4'b1111;  7: return 4'b0111;
      8: return 4'b1110;  9: return 4'b1101; 10: return 4'b1011; 11: return 4'b0110;
      12: return 4'b0101; 13: return 4'b1010; 14: return 4'b1001; default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] d, input logic on);
    return on ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [21:0] a, input logic [31:0] d,
                        input logic [1:0] bm);
    @(negedge clk);
    hst_wr = wr; hst_rd = ~wr; hst_addr = a; hst_wdata = d; hst_bmode = bm;
    waits = 0;
    #1;
    while (!hst_ready && waits < 1000) begin
      @(negedge clk); #1; waits++;
    end
    c_req = fb_req; c_we = fb_we; c_addr = fb_addr; c_be = fb_be; c_wd = fb_wdata;
    c_ev = eng_valid; c_cmd = eng_cmd; c_ed = eng_data; c_rd = hst_rdata;
    @(posedge clk); #1;
    hst_wr = 0; hst_rd = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic sw;
    void'($urandom(32'd7731));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 reset state
    chk("R11 irq", irq, 0);
    access(0, A_STAT, 0, 0); chk("R11 status", c_rd, 0);
    access(0, A_CFG, 0, 0);  chk("R11 cfg", c_rd, 0);
    access(0, A_IEN, 0, 0);  chk("R11 ien", c_rd, 0);

    // R1 directed pass-through
    access(1, 22'h2ABCDE, 32'h11223344, 2'd1);
    chk("R1 fb_req", c_req, 1); chk("R1 fb_we", c_we, 1);
    chk("R1 fb_addr", c_addr, 21'h0ABCDE); chk("R1 waits", waits, 0);
    chk("R4 code6", c_be, 4'b1111);

    // R1 R3 R4 random display-memory traffic
    sw = 0;
    for (int i = 0; i < 48; i++) begin
      logic [21:0] a; logic [31:0] d; logic [1:0] bm;
      if (i % 8 == 0) begin
        sw = $urandom_range(0, 1);
        access(1, A_CFG, {31'd0, sw}, 0);
      end
      a = {1'b1, 21'($urandom)}; d = $urandom; bm = 2'($urandom);
      if ($urandom_range(0, 1)) begin
        access(1, a, d, bm);
        chk("R1 addr", c_addr, a[20:0]);
        chk("R4 lanes", c_be, exp_be({bm, a[1:0]}));
        chk("R3 wdata", c_wd, bsw(d, sw));
      end else begin
        fb_rdata = $urandom;
        access(0, a, 0, bm);
        chk("R1 rd req", {c_req, c_we}, 2'b10);
        chk("R4 rd lanes", c_be, 0);
        chk("R3 rdata", c_rd, bsw(fb_rdata, sw));
      end
    end
    access(1, A_CFG, 1, 0);

    // R2 register writes do not reach memory
    access(1, A_IEN, 1, 0); chk("R2 no fb", c_req, 0);

    // R5 pixel write holds until engine ready; swap active
    eng_ready = 0;
    fork begin repeat (3) @(negedge clk); eng_ready = 1; end join_none
    access(1, A_PIX8, 32'hA1B2C3D4, 0);
    chk("R5 waits", waits, 2); chk("R5 cmd", c_cmd, 4);
    chk("R3 eng data", c_ed, 32'hD4C3B2A1); chk("R2 pix no fb", c_req, 0);
    access(1, A_PIX1, 32'h5, 0); chk("R5 cmd mono", c_cmd, 3);

    // R6 launch while idle
    access(0, A_FILL, 0, 0);
    chk("R6 valid", c_ev, 1); chk("R6 cmd", c_cmd, 1);
    access(0, A_STAT, 0, 0); chk("R6 busy", c_rd, 32'h1);

    // R7 launch while busy is dropped
    access(0, A_COPY, 0, 0);
    chk("R7 no valid", c_ev, 0); chk("R7 waits", waits, 0);
    access(0, A_STAT, 0, 0); chk("R7 rejected", c_rd, 32'h3);

    // R10 writes while busy
    access(1, A_IEN, 1, 0); chk("R10 ien no stall", waits, 0);
    fork begin repeat (4) @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0; end join_none
    access(1, A_CFG, 0, 0);
    chk("R10 cfg stalled", waits > 0, 1);
    access(0, A_CFG, 0, 0); chk("R10 cfg applied", c_rd, 0);

    // R8 done cleared busy and raised irq
    chk("R8 irq", irq, 1);
    access(0, A_STAT, 0, 0); chk("R8 status", c_rd, 32'h6);

    // R9 clear alone, then collision with done
    access(1, A_STAT, 32'h4, 0); chk("R9 cleared", irq, 0);
    done_pulse(); chk("R9 pend again", irq, 1);
    @(negedge clk);
    hst_wr = 1; hst_addr = A_STAT; hst_wdata = 32'h4; eng_done = 1;
    @(posedge clk); #1;
    hst_wr = 0; eng_done = 0;
    chk("R9 done wins", irq, 1);
    access(1, A_STAT, 32'h4, 0); chk("R9 clear after", irq, 0);

    // R6 successful launch clears rejected; R8 no irq when disabled
    access(1, A_IEN, 0, 0);
    access(0, A_COPY, 0, 0); chk("R6 copy cmd", c_cmd, 2);
    access(0, A_STAT, 0, 0); chk("R6 rej cleared", c_rd, 32'h1);
    done_pulse();
    access(0, A_STAT, 0, 0); chk("R8 no irq", c_rd, 32'h0);
    chk("R8 irq low", irq, 0);

    finish_run();
  end
endmodule